// File: doc/BRIEF.md
# Double-Data-Rate Output Serializer with Retimed Second Bit

This block turns pairs of bits into a double-data-rate stream on an output pad. Upstream logic hands over two bits per cycle of a primary clock. The first bit goes out while the primary clock is high. The second bit goes out while the primary clock is low. A second clock, the inverse of the primary one, captures the second bit for the low half-period. A two-input multiplexer, steered by the level of the primary clock, picks the bit that drives the pad.

Parameter `CASCADE` chooses how the second bit reaches the inverse-clock register. With `CASCADE = 1`, the second bit is first latched on the primary clock in a staging register, together with the enable and reset. Only then is it moved onto the inverse clock. Upstream logic therefore works entirely on the primary clock, and each pair goes out first bit then second bit during the cycle after it was taken. With `CASCADE = 0`, the inverse-clock register samples `d_second`, `ce` and `rst` directly at the falling edge of the primary clock. The second bit of a pair then goes out half a cycle before its first bit. Parameter `LANES` sets how many independent pads are served.

The data path has no ready signal and takes no back-pressure. A pair is accepted on every primary rising edge at which `ce` is high. While `ce` is low, nothing is accepted and the pad repeats its last two values. A source that must pause simply lowers `ce`.

Top module: `ddr_cascade_ser`

## Requirements
- R1: With CASCADE=1, during the high half of `clk_a`, each pad shows the `d_first` bit taken at the most recent rising edge of `clk_a` at which `ce` was 1 and `rst` was 0.
- R2: With CASCADE=1, during the low half of `clk_a` that follows, each pad shows the `d_second` bit of that same pair. The pad thus emits first bit, then second bit, one `clk_a` cycle after the pair is presented.
- R3: With CASCADE=1, a change on `d_second`, `ce` or `rst` after a rising edge of `clk_a` has no effect on the pad until the next rising edge. Only the values present at the rising edge of `clk_a` count.
- R4: With CASCADE=0, during the low half of `clk_a`, each pad shows the `d_second` bit present at the falling edge of `clk_a` (rising edge of `clk_b`), provided `ce`=1 and `rst`=0 at that edge.
- R5: With CASCADE=0, during the high half of `clk_a`, each pad shows the `d_first` bit taken at the most recent rising edge of `clk_a` with `ce`=1 and `rst`=0.
- R6: While `rst`=1 at the capturing edges, every register is cleared. The pad then reads 0 in both half-periods, on every lane.
- R7: While `ce`=0 at the capturing edges, no register changes. The pad repeats the same high-half and low-half values, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Primary clock; high half carries the first bit |
| clk_b | input | 1 | Inverse of `clk_a`; captures the second bit |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; low holds every register |
| d_first | input | LANES | Bit sent while `clk_a` is high |
| d_second | input | LANES | Bit sent while `clk_a` is low |
| pad_o | output | LANES | Serialized double-data-rate output |

## Verification
The hardest case to reach from the ports is the one that proves the retiming. In cascade mode, `d_second` must change between the rising and the falling edge of `clk_a`, and the low half-period must still show the older value. The stimulus therefore changes every input a quarter period after each rising edge. The same inputs drive a direct-mode instance, which must show the newer value in the same half-period. Bursts with `ce` low and a reset in mid-stream then check that, in cascade mode, a pair already staged keeps its second bit across a stall.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;
  // Control bits that accompany data into the inverse-clock register.
  typedef struct packed {
    logic clr;
    logic en;
  } ctl_t;
endpackage

// File: rtl/ddr_launch_stage.sv
module ddr_launch_stage
  import ddr_ser_pkg::*;
#(
  parameter int LANES   = 1,
  parameter bit CASCADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [LANES-1:0] d_first,
  input  logic [LANES-1:0] d_second,
  output logic [LANES-1:0] rise_q,
  output logic [LANES-1:0] fall_src,
  output ctl_t             fall_ctl
);

  // First bit: captured on the primary rising edge.
  always_ff @(posedge clk) begin
    if (rst)     rise_q <= '0;
    else if (ce) rise_q <= d_first;
  end

  generate
    if (CASCADE) begin : g_stage
      logic [LANES-1:0] stage_q;
      ctl_t             ctl_q;

      // Second bit staged on the primary clock.
      always_ff @(posedge clk) begin
        if (rst)     stage_q <= '0;
        else if (ce) stage_q <= d_second;
      end

      // Enable and reset travel with the staged bit.
      always_ff @(posedge clk) begin
        ctl_q <= '{clr: rst, en: ce};
      end

      assign fall_src = stage_q;
      assign fall_ctl = ctl_q;

      AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(stage_q)) else $error("staging register moved"); // R7
    end else begin : g_direct
      assign fall_src = d_second;
      assign fall_ctl = '{clr: rst, en: ce};
    end
  endgenerate

  AST_RISE_CLEAR: assert property (@(posedge clk)
    rst |=> (rise_q == '0)) else $error("rise register not cleared"); // R6
  AST_RISE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(rise_q)) else $error("rise register moved"); // R7

endmodule

// File: rtl/ddr_fall_reg.sv
module ddr_fall_reg
  import ddr_ser_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  ctl_t             ctl,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);

  always_ff @(posedge clk) begin
    if (ctl.clr)     q <= '0;
    else if (ctl.en) q <= d;
  end

  AST_FALL_CLEAR: assert property (@(posedge clk)
    ctl.clr |=> (q == '0)) else $error("fall register not cleared"); // R6
  AST_FALL_HOLD: assert property (@(posedge clk) disable iff (ctl.clr)
    !ctl.en |=> $stable(q)) else $error("fall register moved"); // R7

endmodule

// File: rtl/ddr_phase_mux.sv
module ddr_phase_mux #(
  parameter int LANES = 1
) (
  input  logic             phase,
  input  logic [LANES-1:0] hi,
  input  logic [LANES-1:0] lo,
  output logic [LANES-1:0] pad
);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign pad[i] = phase ? hi[i] : lo[i];
    end
  endgenerate

endmodule

// File: rtl/ddr_cascade_ser.sv
module ddr_cascade_ser
  import ddr_ser_pkg::*;
#(
  parameter int LANES   = 1,
  parameter bit CASCADE = 1'b1
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst,
  input  logic             ce,
  input  logic [LANES-1:0] d_first,
  input  logic [LANES-1:0] d_second,
  output logic [LANES-1:0] pad_o
);

  logic [LANES-1:0] rise_q;
  logic [LANES-1:0] fall_src;
  logic [LANES-1:0] fall_q;
  ctl_t             fall_ctl;

  ddr_launch_stage #(.LANES(LANES), .CASCADE(CASCADE)) u_launch (
    .clk      (clk_a),
    .rst      (rst),
    .ce       (ce),
    .d_first  (d_first),
    .d_second (d_second),
    .rise_q   (rise_q),
    .fall_src (fall_src),
    .fall_ctl (fall_ctl)
  );

  ddr_fall_reg #(.LANES(LANES)) u_fall (
    .clk (clk_b),
    .ctl (fall_ctl),
    .d   (fall_src),
    .q   (fall_q)
  );

  ddr_phase_mux #(.LANES(LANES)) u_mux (
    .phase (clk_a),
    .hi    (rise_q),
    .lo    (fall_q),
    .pad   (pad_o)
  );

  AST_FIRST_TAKEN: assert property (@(posedge clk_a) disable iff (rst)
    ce |=> (rise_q == $past(d_first))) else $error("first bit not taken"); // R1

endmodule

// File: tb/tb_ddr_cascade_ser.sv
module tb_ddr_cascade_ser;
  localparam int CLK_PERIOD = 16;
  localparam int L = 2;

  logic         clk_a = 1'b0;
  logic         clk_b;
  logic         rst = 1'b1;
  logic         ce = 1'b0;
  logic [L-1:0] d_first = '0;
  logic [L-1:0] d_second = '0;
  logic [L-1:0] pad_c;
  logic [L-1:0] pad_d;

  int checks = 0;
  int failures = 0;

  // Reference state, built from the requirements.
  logic [L-1:0] c_hi = '0, c_lo = '0, d_hi = '0, d_lo = '0;
  logic         last_rst = 1'b1, last_ce = 1'b0;
  logic         fall_rst = 1'b1, fall_ce = 1'b0;

  always #(CLK_PERIOD/2) clk_a = ~clk_a;
  assign clk_b = ~clk_a;

  ddr_cascade_ser #(.LANES(L), .CASCADE(1'b1)) dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .ce(ce),
    .d_first(d_first), .d_second(d_second), .pad_o(pad_c)
  );

  ddr_cascade_ser #(.LANES(L), .CASCADE(1'b0)) dut_direct (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .ce(ce),
    .d_first(d_first), .d_second(d_second), .pad_o(pad_d)
  );

  task automatic check(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // One primary cycle: rising update, high-half check, new drive,
  // falling update, low-half check.
  task automatic step(input logic r, input logic e, input logic [L-1:0] a, input logic [L-1:0] b);
    string hi_c, hi_d, lo_c, lo_d;
    @(posedge clk_a);
    last_rst = rst;
    last_ce  = ce;
    if (rst) begin
      c_hi = '0; c_lo = '0; d_hi = '0;
    end else if (ce) begin
      c_hi = d_first; c_lo = d_second; d_hi = d_first;
    end
    hi_c = last_rst ? "R6" : (!last_ce ? "R7" : "R1");
    hi_d = last_rst ? "R6" : (!last_ce ? "R7" : "R5");
    #(CLK_PERIOD/8);
    check({hi_c, " cascade high half"}, pad_c, c_hi);
    check({hi_d, " direct high half"}, pad_d, d_hi);
    #(CLK_PERIOD/8);
    rst = r; ce = e; d_first = a; d_second = b;
    @(posedge clk_b);
    fall_rst = rst;
    fall_ce  = ce;
    if (rst)     d_lo = '0;
    else if (ce) d_lo = d_second;
    if (last_rst)                                       lo_c = "R6";
    else if (!last_ce)                                  lo_c = "R7";
    else if (d_second != c_lo || rst != last_rst || ce != last_ce) lo_c = "R3";
    else                                                lo_c = "R2";
    lo_d = fall_rst ? "R6" : (!fall_ce ? "R7" : "R4");
    #(CLK_PERIOD/8);
    check({lo_c, " cascade low half"}, pad_c, c_lo);
    check({lo_d, " direct low half"}, pad_d, d_lo);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    // Reset phase (R6): data toggling must not reach the pad.
    step(1'b1, 1'b1, 2'b11, 2'b11);
    step(1'b1, 1'b1, 2'b10, 2'b01);
    step(1'b1, 1'b0, 2'b11, 2'b11);
    // Fixed patterns (R1 R2 R4 R5), each lane distinct.
    step(1'b0, 1'b1, 2'b01, 2'b10);
    step(1'b0, 1'b1, 2'b10, 2'b01);
    step(1'b0, 1'b1, 2'b11, 2'b00);
    step(1'b0, 1'b1, 2'b00, 2'b11);
    // Random stream with enable always high.
    for (int i = 0; i < 40; i++)
      step(1'b0, 1'b1, L'($urandom()), L'($urandom()));
    // Stall (R7): data moves while ce is low.
    step(1'b0, 1'b1, 2'b10, 2'b01);
    for (int i = 0; i < 5; i++)
      step(1'b0, 1'b0, ~L'(i), L'(i));
    // Random enable pattern (R3 R7).
    for (int i = 0; i < 40; i++)
      step(1'b0, 1'($urandom()), L'($urandom()), L'($urandom()));
    // Reset mid-stream (R6), then recovery.
    step(1'b0, 1'b1, 2'b11, 2'b11);
    step(1'b1, 1'b1, 2'b11, 2'b11);
    step(1'b1, 1'b0, 2'b01, 2'b10);
    for (int i = 0; i < 20; i++)
      step(1'($urandom() % 8 == 0), 1'($urandom() % 4 != 0), L'($urandom()), L'($urandom()));
    step(1'b0, 1'b1, 2'b00, 2'b00);
    step(1'b0, 1'b1, 2'b00, 2'b00);
    finish_run();
  end
endmodule